// File: doc/BRIEF.md
# Synchronous DRAM Burst Data Path with Byte Masks

This block is the device-side data engine of a 32-bit synchronous DRAM. The storage is a single page of columns held in a small register array. A read or write command names a start column. The engine then steps through the columns of a burst, one per clock. The burst length, the column order (linear or XOR-interleaved) and the read latency all come from a mode setting that is loaded beforehand.

Write data enters in the same cycle as the write command. Each later burst word enters on the next clock. Read data leaves the block after the programmed latency of two or three clocks. A per-byte output enable is high only while a read word is on the bus and its byte is not masked. Four byte-mask inputs block data lanes. On writes they act in the cycle they are sampled. On reads they act two cycles after they are sampled.

A read or write command that arrives during a burst cuts the burst short and starts a new one at once. Back-to-back read bursts therefore give continuous output. A stop command ends a burst of any length.

Top module: `sdram_burst_dp`

## Requirements
- R1: After reset, all bits of `dout_oe` are low and no burst is running. The mode defaults to length 1, linear order and latency 2.
- R2: When `mode_cl3`=0, the first read word is valid at the second rising edge after the read command. When `mode_cl3`=1, it is valid at the third rising edge.
- R3: The `mode_bl` codes 0, 1, 2 and 3 select bursts of 1, 2, 4 and 8 words. Codes 4 to 7 select a full page of 2^COL_W words. Each burst produces exactly that many column accesses unless it is cut short.
- R4: In linear order, word k of a burst of length L that starts at column s uses column (s − s mod L) + ((s mod L + k) mod L). The burst therefore wraps inside the L-aligned block.
- R5: In interleaved order (`mode_il`=1), word k uses column (s − s mod L) + ((s mod L) XOR k). Full-page bursts always use linear order.
- R6: `cmd` code 2 is a write. The word on `din` in the command cycle is stored at the start column, and the following words are stored on consecutive cycles at the next burst columns.
- R7: During a write, `dqm` bit i sampled high in a cycle leaves bits 8i+7:8i of that cycle's column unchanged. The mask has no delay.
- R8: During a read, `dqm` bit i sampled high at an edge drives `dout_oe` bit i low during the cycle that is sampled at the second edge after it.
- R9: `dout_oe` returns to all-low after the last word of a read burst. A new read issued exactly one burst length after the previous one gives output with no idle cycle.
- R10: `cmd` code 1 (read) or code 2 (write) arriving while a burst is running ends that burst and starts the new burst at the new column in the same cycle.
- R11: `cmd` code 3 (stop) ends any burst. No further column is read or written until the next command. Code 0 is no operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_load | input | 1 | Loads the three mode fields at this edge |
| mode_bl | input | 3 | Burst length code |
| mode_il | input | 1 | 1 selects interleaved order |
| mode_cl3 | input | 1 | 1 selects read latency 3, 0 selects latency 2 |
| cmd | input | 2 | 0 no operation, 1 read, 2 write, 3 stop |
| col | input | COL_W | Start column of a read or write |
| dqm | input | BYTES | Per-byte data mask |
| din | input | 8*BYTES | Write data |
| dout | output | 8*BYTES | Read data |
| dout_oe | output | BYTES | Per-byte output drive enable |

## Verification
The assertions check the following on every cycle:
- A stop always clears the burst, and a new command always restarts the counter at the sampled column.
- A running burst never leaves its aligned block, and the burst ends once its last word is used.
- An enabled output lane always traces back to a read issued the programmed latency earlier.
- An enabled output lane was never masked two cycles before.

The bench scenarios cover the following:
- Whether the burst columns come in the right order and carry the right data.
- Whether masked write bytes survive.
- Whether interrupted and gapless bursts deliver the expected words.

The bench compares every one of these against its own model of the memory.

// File: rtl/sdram_dp_pkg.sv
package sdram_dp_pkg;

  typedef enum logic [1:0] {
    CMD_NOP  = 2'd0,
    CMD_RD   = 2'd1,
    CMD_WR   = 2'd2,
    CMD_STOP = 2'd3
  } dp_cmd_e;

endpackage

// File: rtl/sdram_col_gen.sv
// Column sequencer: maps start column and burst index to the accessed column.
module sdram_col_gen #(
  parameter int COL_W = 5
) (
  input  logic [COL_W-1:0] start_col,
  input  logic [COL_W-1:0] idx,
  input  logic [COL_W-1:0] blk_mask,
  input  logic             xor_order,
  output logic [COL_W-1:0] cur_col
);

  logic [COL_W-1:0] base;
  logic [COL_W-1:0] lin_off;
  logic [COL_W-1:0] xor_off;

  always_comb begin
    base    = start_col & ~blk_mask;
    lin_off = (start_col + idx) & blk_mask;
    xor_off = (start_col ^ idx) & blk_mask;
    cur_col = base | (xor_order ? xor_off : lin_off);
  end

endmodule

// File: rtl/sdram_burst_ctrl.sv
// Mode holding, burst state and per-cycle operation select.
module sdram_burst_ctrl
  import sdram_dp_pkg::*;
#(
  parameter int COL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_load,
  input  logic [2:0]       mode_bl,
  input  logic             mode_il,
  input  logic             mode_cl3,
  input  logic [1:0]       cmd,
  input  logic [COL_W-1:0] col,
  output logic             op_valid,
  output logic             op_wr,
  output logic [COL_W-1:0] op_addr,
  output logic             cl3
);

  logic [2:0]       bl_q;
  logic             il_q;
  logic             cl3_q;

  logic             act_q, act_n;
  logic             wr_q, wr_n;
  logic             ilb_q, ilb_n;
  logic [COL_W-1:0] start_q, start_n;
  logic [COL_W-1:0] cnt_q, cnt_n;
  logic [COL_W-1:0] mask_q, mask_n;
  logic [COL_W-1:0] cur_mask;
  logic [COL_W-1:0] gen_addr;
  dp_cmd_e          c;

  assign c   = dp_cmd_e'(cmd);
  assign cl3 = cl3_q;

  always_comb begin
    case (bl_q)
      3'd0:    cur_mask = '0;
      3'd1:    cur_mask = COL_W'(1);
      3'd2:    cur_mask = COL_W'(3);
      3'd3:    cur_mask = COL_W'(7);
      default: cur_mask = '1;
    endcase
  end

  sdram_col_gen #(.COL_W(COL_W)) col_gen_i (
    .start_col (start_q),
    .idx       (cnt_q),
    .blk_mask  (mask_q),
    .xor_order (ilb_q),
    .cur_col   (gen_addr)
  );

  always_comb begin
    op_valid = 1'b0;
    op_wr    = 1'b0;
    op_addr  = gen_addr;
    act_n    = act_q;
    wr_n     = wr_q;
    ilb_n    = ilb_q;
    start_n  = start_q;
    cnt_n    = cnt_q;
    mask_n   = mask_q;
    if (c == CMD_RD || c == CMD_WR) begin
      op_valid = 1'b1;
      op_wr    = (c == CMD_WR);
      op_addr  = col;
      wr_n     = (c == CMD_WR);
      start_n  = col;
      cnt_n    = COL_W'(1);
      mask_n   = cur_mask;
      ilb_n    = il_q && (cur_mask != '1);
      act_n    = (cur_mask != '0);
    end else if (c == CMD_STOP) begin
      act_n = 1'b0;
    end else if (act_q) begin
      op_valid = 1'b1;
      op_wr    = wr_q;
      cnt_n    = cnt_q + COL_W'(1);
      act_n    = (cnt_q != mask_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bl_q  <= 3'd0;
      il_q  <= 1'b0;
      cl3_q <= 1'b0;
    end else if (mode_load) begin
      bl_q  <= mode_bl;
      il_q  <= mode_il;
      cl3_q <= mode_cl3;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      wr_q    <= 1'b0;
      ilb_q   <= 1'b0;
      start_q <= '0;
      cnt_q   <= '0;
      mask_q  <= '0;
    end else begin
      act_q   <= act_n;
      wr_q    <= wr_n;
      ilb_q   <= ilb_n;
      start_q <= start_n;
      cnt_q   <= cnt_n;
      mask_q  <= mask_n;
    end
  end

  // R11
  stop_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c == CMD_STOP) |=> !act_q);

  // R10
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c == CMD_RD || c == CMD_WR) |=> (cnt_q == COL_W'(1) && start_q == $past(col)));

  // R4
  in_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && c == CMD_NOP) |-> ((op_addr & ~mask_q) == (start_q & ~mask_q)));

  // R3
  burst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && c == CMD_NOP && cnt_q == mask_q) |=> !act_q);

endmodule

// File: rtl/sdram_byte_mem.sv
// Byte-lane column storage with registered read port.
module sdram_byte_mem #(
  parameter int COL_W = 5,
  parameter int BYTES = 4
) (
  input  logic               clk,
  input  logic               we,
  input  logic               re,
  input  logic [COL_W-1:0]   addr,
  input  logic [8*BYTES-1:0] wdata,
  input  logic [BYTES-1:0]   wmask,
  output logic [8*BYTES-1:0] rdata
);

  localparam int DEPTH = 1 << COL_W;

  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    logic [7:0] lane_q [DEPTH];
    logic [7:0] rd_q;

    always_ff @(posedge clk) begin
      if (we && !wmask[b]) begin
        lane_q[addr] <= wdata[8*b +: 8];
      end
    end

    always_ff @(posedge clk) begin
      if (re) begin
        rd_q <= lane_q[addr];
      end
    end

    assign rdata[8*b +: 8] = rd_q;
  end

endmodule

// File: rtl/sdram_rd_pipe.sv
// Read latency pipeline and delayed byte masking of the output.
module sdram_rd_pipe #(
  parameter int BYTES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_fire,
  input  logic [8*BYTES-1:0] rdata,
  input  logic               cl3,
  input  logic [BYTES-1:0]   dqm,
  output logic [8*BYTES-1:0] dout,
  output logic [BYTES-1:0]   dout_oe
);

  localparam int DW = 8 * BYTES;

  logic             v1_q, v2_q, v3_q;
  logic [DW-1:0]    d2_q, d3_q;
  logic [BYTES-1:0] dm1_q, dm2_q;
  logic             vsel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q  <= 1'b0;
      v2_q  <= 1'b0;
      v3_q  <= 1'b0;
      dm1_q <= '0;
      dm2_q <= '0;
    end else begin
      v1_q  <= rd_fire;
      v2_q  <= v1_q;
      v3_q  <= v2_q;
      dm1_q <= dqm;
      dm2_q <= dm1_q;
    end
  end

  always_ff @(posedge clk) begin
    if (v1_q) d2_q <= rdata;
    if (v2_q) d3_q <= d2_q;
  end

  always_comb begin
    vsel    = cl3 ? v3_q : v2_q;
    dout    = cl3 ? d3_q : d2_q;
    dout_oe = vsel ? ~dm2_q : '0;
  end

  // R8
  rd_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_oe & $past(dqm, 2)) == '0);

  // R2
  lat2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cl3 && dout_oe != '0) |-> $past(rd_fire, 2));

  // R2
  lat3_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cl3 && dout_oe != '0) |-> $past(rd_fire, 3));

endmodule

// File: rtl/sdram_burst_dp.sv
// Top: burst data path of a synchronous DRAM page.
module sdram_burst_dp #(
  parameter int COL_W = 5,
  parameter int BYTES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_load,
  input  logic [2:0]         mode_bl,
  input  logic               mode_il,
  input  logic               mode_cl3,
  input  logic [1:0]         cmd,
  input  logic [COL_W-1:0]   col,
  input  logic [BYTES-1:0]   dqm,
  input  logic [8*BYTES-1:0] din,
  output logic [8*BYTES-1:0] dout,
  output logic [BYTES-1:0]   dout_oe
);

  localparam int DW = 8 * BYTES;

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             op_valid;
  logic             op_wr;
  logic [COL_W-1:0] op_addr;
  logic             cl3;
  logic [DW-1:0]    rdata;
  logic             rd_fire;
  logic             wr_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign rd_fire = op_valid && !op_wr;
  assign wr_fire = op_valid && op_wr;

  sdram_burst_ctrl #(.COL_W(COL_W)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .mode_load (mode_load),
    .mode_bl   (mode_bl),
    .mode_il   (mode_il),
    .mode_cl3  (mode_cl3),
    .cmd       (cmd),
    .col       (col),
    .op_valid  (op_valid),
    .op_wr     (op_wr),
    .op_addr   (op_addr),
    .cl3       (cl3)
  );

  sdram_byte_mem #(.COL_W(COL_W), .BYTES(BYTES)) mem_i (
    .clk   (clk),
    .we    (wr_fire),
    .re    (rd_fire),
    .addr  (op_addr),
    .wdata (din),
    .wmask (dqm),
    .rdata (rdata)
  );

  sdram_rd_pipe #(.BYTES(BYTES)) pipe_i (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .rd_fire (rd_fire),
    .rdata   (rdata),
    .cl3     (cl3),
    .dqm     (dqm),
    .dout    (dout),
    .dout_oe (dout_oe)
  );

endmodule

// File: tb/sdram_burst_dp_tb.sv
module sdram_burst_dp_tb_top;

  localparam int COL_W = 5;
  localparam int NCOL  = 1 << COL_W;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_load = 1'b0;
  logic [2:0]  mode_bl = 3'd0;
  logic        mode_il = 1'b0;
  logic        mode_cl3 = 1'b0;
  logic [1:0]  cmd = 2'd0;
  logic [4:0]  col = '0;
  logic [3:0]  dqm = '0;
  logic [31:0] din = '0;
  logic [31:0] dout;
  logic [3:0]  dout_oe;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  string cur_req = "R1";

  // model state
  logic [31:0] mm [NCOL];
  bit          s_vld [16];
  logic [31:0] s_dat [16];
  logic [3:0]  s_msk [16];
  int m_bl = 0; bit m_il = 0; bit m_cl3 = 0;
  bit b_act = 0; bit b_wr = 0; bit b_il = 0;
  int b_start = 0; int b_idx = 0; int b_left = 0; int b_len = 1;

  always #5 clk = ~clk;

  sdram_burst_dp #(.COL_W(COL_W), .BYTES(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_bl(mode_bl),
    .mode_il(mode_il), .mode_cl3(mode_cl3), .cmd(cmd), .col(col),
    .dqm(dqm), .din(din), .dout(dout), .dout_oe(dout_oe)
  );

  function automatic int len_of(int code);
    case (code)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 8;
      default: return NCOL;
    endcase
  endfunction

  function automatic int exp_col(int st, int idx, int len, bit il);
    int off, base;
    off  = st % len;
    base = st - off;
    if (il && len != NCOL) return base + (off ^ idx);
    return base + ((off + idx) % len);
  endfunction

  task automatic model_op(int e, int a, bit w);
    if (w) begin
      for (int b = 0; b < 4; b++)
        if (!dqm[b]) mm[a][8*b +: 8] = din[8*b +: 8];
    end else begin
      int sl;
      sl = (e + (m_cl3 ? 3 : 2) - 1) % 16;
      s_vld[sl] = 1'b1;
      s_dat[sl] = mm[a];
    end
  endtask

  task automatic model_edge(int e);
    if (cmd == 2'd1 || cmd == 2'd2) begin
      b_wr = (cmd == 2'd2);
      b_start = int'(col);
      b_len = len_of(m_bl);
      b_il = m_il;
      b_idx = 1;
      b_left = b_len - 1;
      b_act = (b_left > 0);
      model_op(e, b_start, b_wr);
    end else if (cmd == 2'd3) begin
      b_act = 0;
    end else if (b_act) begin
      model_op(e, exp_col(b_start, b_idx, b_len, b_il), b_wr);
      b_idx++;
      b_left--;
      b_act = (b_left > 0);
    end
    s_msk[(e + 1) % 16] = dqm;
    if (mode_load) begin
      m_bl = int'(mode_bl);
      m_il = mode_il;
      m_cl3 = mode_cl3;
    end
  endtask

  task automatic check_out();
    int sl;
    logic [3:0] eo;
    sl = cyc % 16;
    eo = s_vld[sl] ? ~s_msk[sl] : 4'h0;
    checks++;
    if (dout_oe !== eo) begin
      errors++;
      $display("FAIL %s cycle %0d dout_oe act=%h exp=%h", cur_req, cyc, dout_oe, eo);
    end else begin
      for (int b = 0; b < 4; b++)
        if (eo[b] && dout[8*b +: 8] !== s_dat[sl][8*b +: 8]) begin
          errors++;
          $display("FAIL %s cycle %0d byte %0d act=%h exp=%h", cur_req, cyc, b,
                   dout[8*b +: 8], s_dat[sl][8*b +: 8]);
        end
    end
    s_vld[sl] = 1'b0;
  endtask

  task automatic step(logic [1:0] c, int cl, logic [3:0] dm, logic [31:0] d);
    @(negedge clk);
    check_out();
    cmd = c; col = 5'(cl); dqm = dm; din = d;
    @(posedge clk);
    model_edge(cyc + 1);
    cyc++;
    mode_load = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(2'd0, 0, 4'h0, $urandom);
  endtask

  task automatic set_mode(int bl, bit il, bit c3);
    @(negedge clk);
    mode_bl = 3'(bl); mode_il = il; mode_cl3 = c3; mode_load = 1'b1;
    step(2'd0, 0, 4'h0, 32'h0);
  endtask

  task automatic burst(logic [1:0] c, int cl, int n, logic [3:0] dm);
    step(c, cl, dm, $urandom);
    for (int i = 1; i < n; i++) step(2'd0, 0, dm, $urandom);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 16; i++) begin s_vld[i] = 0; s_msk[i] = 0; s_dat[i] = 0; end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    // R1: outputs quiet and defaults in force
    cur_req = "R1";
    idle(3);
    // R1 default length 1, latency 2: first write/read use defaults
    step(2'd2, 3, 4'h0, 32'hA5A5_0003);
    step(2'd1, 3, 4'h0, 32'h0);
    idle(4);
    // R3 / R6: full page write fills all columns
    cur_req = "R6";
    set_mode(7, 0, 0);
    burst(2'd2, 0, NCOL, 4'h0);
    idle(2);
    cur_req = "R3";
    burst(2'd1, 9, NCOL, 4'h0);
    idle(4);
    // R4: linear BL8 from mid-block
    cur_req = "R4";
    set_mode(3, 0, 0);
    burst(2'd1, 13, 8, 4'h0);
    idle(4);
    // R5: interleaved BL8 and BL4
    cur_req = "R5";
    set_mode(3, 1, 0);
    burst(2'd1, 21, 8, 4'h0);
    idle(3);
    set_mode(2, 1, 0);
    burst(2'd1, 6, 4, 4'h0);
    idle(4);
    // R7: masked write, then read back
    cur_req = "R7";
    set_mode(2, 0, 0);
    step(2'd2, 10, 4'b0101, 32'h1111_1111);
    step(2'd0, 0, 4'b1010, 32'h2222_2222);
    step(2'd0, 0, 4'b1111, 32'h3333_3333);
    step(2'd0, 0, 4'b0000, 32'h4444_4444);
    burst(2'd1, 8, 4, 4'h0);
    idle(4);
    // R2: latency 3
    cur_req = "R2";
    set_mode(1, 0, 1);
    burst(2'd1, 30, 2, 4'h0);
    idle(5);
    // R8: read mask, two-cycle latency
    cur_req = "R8";
    set_mode(3, 0, 0);
    step(2'd1, 0, 4'b0001, 32'h0);
    step(2'd0, 0, 4'b0110, 32'h0);
    step(2'd0, 0, 4'b1000, 32'h0);
    step(2'd0, 0, 4'b0000, 32'h0);
    step(2'd0, 0, 4'b1111, 32'h0);
    idle(6);
    // R9: gapless back-to-back BL2 reads, then bus release
    cur_req = "R9";
    set_mode(1, 0, 0);
    burst(2'd1, 4, 2, 4'h0);
    burst(2'd1, 17, 2, 4'h0);
    burst(2'd1, 25, 2, 4'h0);
    idle(5);
    // R10: interrupting reads and writes
    cur_req = "R10";
    set_mode(3, 0, 0);
    burst(2'd1, 0, 3, 4'h0);
    burst(2'd1, 16, 2, 4'h0);
    burst(2'd2, 24, 3, 4'h0);
    burst(2'd1, 24, 8, 4'h0);
    idle(5);
    // R11: stop during write and during read
    cur_req = "R11";
    set_mode(7, 0, 0);
    burst(2'd2, 2, 3, 4'h0);
    step(2'd3, 0, 4'h0, 32'hDEAD_BEEF);
    idle(4);
    set_mode(3, 0, 0);
    burst(2'd1, 0, 8, 4'h0);
    burst(2'd1, 8, 3, 4'h0);
    step(2'd3, 0, 4'h0, 32'h0);
    idle(6);
    // R10 random mix
    cur_req = "R10";
    for (int seg = 0; seg < 40; seg++) begin
      step(2'd3, 0, 4'h0, 32'h0);
      idle(5);
      set_mode($urandom_range(0, 7), 1'($urandom), 1'($urandom));
      for (int i = 0; i < 40; i++) begin
        int r;
        logic [1:0] c;
        logic [3:0] dm;
        r = $urandom_range(0, 99);
        c = (r < 55) ? 2'd0 : (r < 75) ? 2'd1 : (r < 93) ? 2'd2 : 2'd3;
        dm = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'h0;
        step(c, $urandom_range(0, NCOL - 1), dm, $urandom);
      end
    end
    step(2'd3, 0, 4'h0, 32'h0);
    idle(6);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule